// File: doc/BRIEF.md
# Fastlock Charge-Pump Current Controller

This block chooses which of two programmed charge-pump current codes is sent to the pump. A normal (slow) code is used while the loop is settled. A boost (fast) code is used for a while after a new divider value is written, so that the loop settles sooner. Software arms the boost by setting the gain bit in a feedback-divider latch write. The boost then ends in one of two ways. In the manual mode, only a later latch write with the gain bit at zero ends it. In the timed mode, a counter of phase-detector ticks ends it and asks the latch logic to clear its stored gain bit.

The block sits beside the divider latches. It reads the function-latch fields (fastlock enable, mode, a 4-bit timeout code and the two 3-bit current codes). It also reads the gain bit and the write strobe of the divider latch, and a one-cycle tick at the phase-detector rate. Power-down and the counter-reset control both return it to its idle state.

Top module: `fastlock_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `cp_code` equals `cur_slow` and `gain_clr` is 0.
- R2: While `fl_enable` is 0, `cp_code` equals `cur_slow` in every cycle, whatever gain bit was written, and `gain_clr` stays 0.
- R3: A cycle with `nlatch_wr`=1 and `nlatch_gain`=1 (no power-down, no counter reset) makes `cp_code` equal `cur_fast` from the next cycle on, as long as `fl_enable` is 1.
- R4: With `fl_mode`=0 (manual), the fast code stays selected for any number of ticks, and `gain_clr` is never raised. Only a write with `nlatch_gain`=0 selects `cur_slow` again, from the cycle after that write.
- R5: With `fl_mode`=1 (timed), the boost lasts (`tc_code`+1)×4 ticks. `tc_code` is an unsigned 4-bit value, so the range is 4 to 64 ticks. The tick that completes the count makes `cp_code` return to `cur_slow` from the next cycle on. In that same next cycle, `gain_clr` is high for exactly one cycle.
- R6: A write with `nlatch_gain`=1 during a timed boost restarts the count from zero.
- R7: `pwr_down`=1 or `cnt_reset`=1 ends any boost and clears the tick count, so `cp_code` equals `cur_slow` from the next cycle on. Either control takes priority over a latch write in the same cycle.
- R8: A tick that comes in the same cycle as a latch write is not counted.
- R9: `cp_code` follows the selected 3-bit code in the same cycle in which that code's input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fl_enable | input | 1 | Fastlock enable |
| fl_mode | input | 1 | 0 manual, 1 timed |
| tc_code | input | 4 | Timeout code, (code+1)×4 ticks |
| cur_slow | input | 3 | Normal current code |
| cur_fast | input | 3 | Boost current code |
| nlatch_wr | input | 1 | Divider latch write strobe |
| nlatch_gain | input | 1 | Gain bit of that write |
| pfd_tick | input | 1 | Phase-detector rate tick |
| pwr_down | input | 1 | Power-down, forces idle |
| cnt_reset | input | 1 | Counter reset, forces idle |
| cp_code | output | 3 | Current code driven to the pump |
| gain_clr | output | 1 | One-cycle request to clear the stored gain bit |

## Verification
The bench drives the manual mode with long runs of ticks. This separates a correct design from one that lets the timer run in the wrong mode. Timed boosts are tried at the shortest, a middle and the longest timeout, with ticks on every cycle and with gaps between them. These runs expose off-by-one limits and ticks that are counted without being present. Rewrites in the middle of a count, writes in the same cycle as a tick, and power-down or counter reset in the same cycle as a write each test one priority rule. Changing the current codes while a boost is held confirms that the output follows the selected code without delay.

// File: rtl/fastlock_ctrl.sv
module fastlock_ctrl #(
  parameter int CODE_W     = 3,
  parameter int TC_W       = 4,
  parameter int TICK_SCALE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fl_enable,
  input  logic              fl_mode,
  input  logic [TC_W-1:0]   tc_code,
  input  logic [CODE_W-1:0] cur_slow,
  input  logic [CODE_W-1:0] cur_fast,
  input  logic              nlatch_wr,
  input  logic              nlatch_gain,
  input  logic              pfd_tick,
  input  logic              pwr_down,
  input  logic              cnt_reset,
  output logic [CODE_W-1:0] cp_code,
  output logic              gain_clr
);
  localparam int MAX_TICKS = (1 << TC_W) * TICK_SCALE;
  localparam int CNT_W     = $clog2(MAX_TICKS + 1);

  function automatic logic [CNT_W-1:0] timeout_ticks(input logic [TC_W-1:0] code);
    return CNT_W'((int'(code) + 1) * TICK_SCALE);
  endfunction

  logic             boost;
  logic             clr_q;
  logic [CNT_W-1:0] cnt;

  wire              idle_force = pwr_down | cnt_reset;
  wire              timing     = fl_enable & fl_mode & boost;
  wire [CNT_W-1:0]  cnt_nxt    = cnt + CNT_W'(1);
  wire              expire     = timing & pfd_tick & (cnt_nxt >= timeout_ticks(tc_code));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boost <= 1'b0;
      cnt   <= '0;
      clr_q <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (idle_force) begin
        boost <= 1'b0;
        cnt   <= '0;
      end else if (nlatch_wr) begin
        boost <= nlatch_gain;
        cnt   <= '0;
      end else if (expire) begin
        boost <= 1'b0;
        cnt   <= '0;
        clr_q <= 1'b1;
      end else if (timing && pfd_tick) begin
        cnt   <= cnt_nxt;
      end
    end
  end

  assign cp_code  = (fl_enable && boost) ? cur_fast : cur_slow;
  assign gain_clr = clr_q;
endmodule

// File: rtl/fastlock_ctrl_chk.sv
module fastlock_ctrl_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fl_enable,
  input logic              fl_mode,
  input logic [CODE_W-1:0] cur_slow,
  input logic [CODE_W-1:0] cur_fast,
  input logic              nlatch_wr,
  input logic              nlatch_gain,
  input logic              pwr_down,
  input logic              cnt_reset,
  input logic [CODE_W-1:0] cp_code,
  input logic              gain_clr
);
  AST_DISABLED_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_enable |-> (cp_code == cur_slow && !gain_clr)); // R2

  AST_WRITE_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (nlatch_wr && nlatch_gain && !pwr_down && !cnt_reset) |=> (!fl_enable || cp_code == cur_fast)); // R3

  AST_MANUAL_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |-> $past(fl_mode && fl_enable)); // R4

  AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |=> !gain_clr); // R5

  AST_CLR_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |-> cp_code == cur_slow); // R5

  AST_FORCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_down || cnt_reset) |=> cp_code == cur_slow); // R7
endmodule

bind fastlock_ctrl fastlock_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fl_enable(fl_enable), .fl_mode(fl_mode),
  .cur_slow(cur_slow), .cur_fast(cur_fast), .nlatch_wr(nlatch_wr),
  .nlatch_gain(nlatch_gain), .pwr_down(pwr_down), .cnt_reset(cnt_reset),
  .cp_code(cp_code), .gain_clr(gain_clr)
);

// File: tb/sim_fastlock_ctrl.sv
`timescale 1ns/1ps
module sim_fastlock_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fl_enable = 1'b0, fl_mode = 1'b0;
  logic [3:0] tc_code = '0;
  logic [2:0] cur_slow = 3'd2, cur_fast = 3'd6;
  logic       nlatch_wr = 1'b0, nlatch_gain = 1'b0, pfd_tick = 1'b0;
  logic       pwr_down = 1'b0, cnt_reset = 1'b0;
  logic [2:0] cp_code;
  logic       gain_clr;

  int checks = 0, errors = 0, clr_seen = 0;
  string phase = "R1";
  bit running = 1'b0;

  int m_boost = 0, m_cnt = 0, m_clr = 0;

  always #2.5 clk = ~clk;

  fastlock_ctrl u0 (.*);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_boost = 0; m_cnt = 0; m_clr = 0;
    end else begin
      m_clr = 0;
      if (pwr_down || cnt_reset) begin
        m_boost = 0; m_cnt = 0;
      end else if (nlatch_wr) begin
        m_boost = nlatch_gain; m_cnt = 0;
      end else if (fl_enable && fl_mode && m_boost != 0 && pfd_tick) begin
        m_cnt++;
        if (m_cnt >= (tc_code + 1) * 4) begin
          m_boost = 0; m_cnt = 0; m_clr = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk({phase, " cp_code"}, cp_code, (fl_enable && m_boost != 0) ? cur_fast : cur_slow);
      chk({phase, " gain_clr"}, gain_clr, m_clr);
      if (gain_clr) clr_seen++;
    end
  end

  task automatic step(input bit wr, input bit gain, input bit tick);
    @(posedge clk); #1;
    nlatch_wr = wr; nlatch_gain = gain; pfd_tick = tick;
  endtask

  task automatic idle(input int n, input bit tick);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, tick);
  endtask

  task automatic finish_run;
    running = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    fl_enable = 1'b1; nlatch_wr = 1'b1; nlatch_gain = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset cp_code", cp_code, cur_slow);
    chk("R1 reset gain_clr", gain_clr, 0);
    nlatch_wr = 1'b0; nlatch_gain = 1'b0; fl_enable = 1'b0;
    rst_n = 1'b1;
    running = 1'b1;
    idle(2, 1'b0);

    phase = "R2";
    fl_mode = 1'b1;
    step(1, 1, 0); idle(30, 1);
    step(1, 0, 0); idle(2, 0);

    phase = "R3";
    fl_enable = 1'b1; fl_mode = 1'b0;
    step(1, 1, 0); step(0, 0, 0);
    #1.5; chk("R3 fast after write", cp_code, cur_fast);

    phase = "R4";
    idle(100, 1);
    chk("R4 manual no clr", clr_seen, 0);
    step(1, 0, 0); idle(3, 1);

    phase = "R9";
    step(1, 1, 0); idle(2, 0);
    cur_fast = 3'd7; idle(2, 0);
    cur_fast = 3'd1; cur_slow = 3'd4; idle(2, 0);
    step(1, 0, 0); idle(2, 0);
    cur_slow = 3'd0; idle(2, 0);

    phase = "R5";
    fl_mode = 1'b1;
    tc_code = 4'd0; step(1, 1, 0); idle(3, 1);
    #1.5; chk("R5 still fast before last tick", cp_code, cur_fast);
    idle(3, 1);
    chk("R5 one clear pulse", clr_seen, 1);
    tc_code = 4'd3; step(1, 1, 0);
    for (int i = 0; i < 40; i++) step(0, 0, (i % 3) != 1);
    tc_code = 4'd15; step(1, 1, 0); idle(70, 1);
    chk("R5 clear pulses total", clr_seen, 3);

    phase = "R6";
    tc_code = 4'd1; step(1, 1, 0); idle(6, 1);
    step(1, 1, 0); idle(7, 1);
    #1.5; chk("R6 restarted still fast", cp_code, cur_fast);
    idle(4, 1);

    phase = "R8";
    step(1, 1, 0); idle(7, 1);
    step(1, 1, 1);
    idle(7, 1);
    #1.5; chk("R8 tick with write not counted", cp_code, cur_fast);
    idle(3, 1);

    phase = "R7";
    tc_code = 4'd5; step(1, 1, 0); idle(5, 1);
    pwr_down = 1'b1; step(1, 1, 1); idle(3, 1);
    pwr_down = 1'b0; idle(30, 1);
    step(1, 1, 0); idle(10, 1);
    cnt_reset = 1'b1; idle(3, 1);
    cnt_reset = 1'b0; step(1, 1, 0); idle(25, 1);
    fl_mode = 1'b0; step(1, 1, 0); idle(3, 0);
    cnt_reset = 1'b1; step(0, 0, 0); cnt_reset = 1'b0; idle(3, 0);

    finish_run();
  end
endmodule